// File: doc/BRIEF.md
# Ternary Longest-Prefix Next-Hop Lookup Table

This block resolves the next hop for a 32-bit destination address. It holds a small table of ternary entries. Each entry has a stored value, a care mask, a next-hop index and a valid flag. Every entry is compared with the key in parallel, and bits outside an entry's care mask match either key value. When more than one entry matches, the entry with the lowest table index wins. Software therefore keeps longer prefixes at lower indices so that the most specific route is chosen.

A lookup is started by pulsing the key strobe. One cycle later the block pulses the result strobe and presents the hit flag and the winning next hop. A single write port installs or invalidates one entry per cycle. A write takes effect at the clock edge that ends its cycle, so a lookup issued in the same cycle still sees the old table contents.

Top module: `lpm_tcam`

## Requirements
- R1: After reset, `res_valid_o` and `res_hit_o` are 0, `res_nh_o` is 0, and every entry is invalid, so a lookup issued right after reset misses.
- R2: `res_valid_o` is 1 in the cycle after a cycle with `key_valid_i` = 1, and is 0 in every other cycle.
- R3: A valid entry matches when, for every bit position where its care mask bit is 1, the key bit equals the stored value bit. Value bits at mask positions that are 0 have no effect on the result.
- R4: When several valid entries match, the result carries the next hop of the entry with the lowest index.
- R5: An entry written with `wr_valid_i` = 0 never matches, whatever its value and mask.
- R6: When no valid entry matches, the result has `res_hit_o` = 0 and `res_nh_o` = 0.
- R7: A write in the same cycle as a lookup does not affect that lookup. A lookup in any later cycle sees the written entry.
- R8: A prefix of length L is written with a mask whose top L bits are 1 and whose other bits are 0. A valid entry with an all-zero mask (length 0) matches every key.
- R9: In a cycle without a lookup, `res_hit_o` and `res_nh_o` hold the values from the last lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one table entry this cycle |
| wr_idx_i | input | IDX_W (4) | Index of the entry to write |
| wr_valid_i | input | 1 | Valid flag stored with the entry |
| wr_value_i | input | KEY_W (32) | Stored compare value |
| wr_care_i | input | KEY_W (32) | Care mask; a 1 bit must equal the key bit |
| wr_nh_i | input | NH_W (8) | Next-hop index stored with the entry |
| key_valid_i | input | 1 | Start a lookup this cycle |
| key_i | input | KEY_W (32) | Destination address to look up |
| res_valid_o | output | 1 | Result strobe, one cycle after the key strobe |
| res_hit_o | output | 1 | At least one valid entry matched |
| res_nh_o | output | NH_W (8) | Next hop of the winning entry, 0 on a miss |

## Verification
A corrupted stored entry, a broken match term or a wrong priority order shows at the ports as a wrong `res_hit_o` or `res_nh_o`. It appears one cycle after the first key strobe whose key reaches that entry. An entry that no key covers can hide a fault, so random keys are derived from installed values with their low bits perturbed, which drives overlapping prefixes through the priority logic. A write that takes effect one cycle early or late shows up in the lookup issued alongside it or in the lookup that follows.

// File: rtl/lpm_tcam_pkg.sv
package lpm_tcam_pkg;
  localparam int unsigned DEF_ENTRIES = 16;
  localparam int unsigned DEF_KEY_W   = 32;
  localparam int unsigned DEF_NH_W    = 8;
endpackage

// File: rtl/lpm_tcam_store.sv
module lpm_tcam_store #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned KEY_W     = 32,
  parameter int unsigned NH_W      = 8,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [KEY_W-1:0] wr_value_i,
  input  logic [KEY_W-1:0] wr_care_i,
  input  logic [NH_W-1:0]  wr_nh_i,
  output logic             vld_o  [N_ENTRIES],
  output logic [KEY_W-1:0] val_o  [N_ENTRIES],
  output logic [KEY_W-1:0] care_o [N_ENTRIES],
  output logic [NH_W-1:0]  nh_o   [N_ENTRIES]
);
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_o[i]  <= 1'b0;
        val_o[i]  <= '0;
        care_o[i] <= '0;
        nh_o[i]   <= '0;
      end else if (sel) begin
        vld_o[i]  <= wr_valid_i;
        val_o[i]  <= wr_value_i;
        care_o[i] <= wr_care_i;
        nh_o[i]   <= wr_nh_i;
      end
    end
  end
endmodule

// File: rtl/lpm_tcam_match.sv
module lpm_tcam_match #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned KEY_W     = 32
) (
  input  logic [KEY_W-1:0]     key_i,
  input  logic                 vld_i  [N_ENTRIES],
  input  logic [KEY_W-1:0]     val_i  [N_ENTRIES],
  input  logic [KEY_W-1:0]     care_i [N_ENTRIES],
  output logic [N_ENTRIES-1:0] hit_vec_o
);
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    // mismatches only count on cared bits
    assign hit_vec_o[i] = vld_i[i] && (((key_i ^ val_i[i]) & care_i[i]) == '0);
  end
endmodule

// File: rtl/lpm_tcam_prio.sv
module lpm_tcam_prio #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [N_ENTRIES-1:0] vec_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/lpm_tcam.sv
module lpm_tcam
  import lpm_tcam_pkg::*;
#(
  parameter int unsigned N_ENTRIES = DEF_ENTRIES,
  parameter int unsigned KEY_W     = DEF_KEY_W,
  parameter int unsigned NH_W      = DEF_NH_W,
  localparam int unsigned IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [KEY_W-1:0] wr_value_i,
  input  logic [KEY_W-1:0] wr_care_i,
  input  logic [NH_W-1:0]  wr_nh_i,
  input  logic             key_valid_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             res_valid_o,
  output logic             res_hit_o,
  output logic [NH_W-1:0]  res_nh_o
);
  logic                 ent_vld  [N_ENTRIES];
  logic [KEY_W-1:0]     ent_val  [N_ENTRIES];
  logic [KEY_W-1:0]     ent_care [N_ENTRIES];
  logic [NH_W-1:0]      ent_nh   [N_ENTRIES];
  logic [N_ENTRIES-1:0] hit_vec;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;
  logic [NH_W-1:0]      win_nh;

  lpm_tcam_store #(
    .N_ENTRIES(N_ENTRIES), .KEY_W(KEY_W), .NH_W(NH_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_idx_i   (wr_idx_i),
    .wr_valid_i (wr_valid_i),
    .wr_value_i (wr_value_i),
    .wr_care_i  (wr_care_i),
    .wr_nh_i    (wr_nh_i),
    .vld_o      (ent_vld),
    .val_o      (ent_val),
    .care_o     (ent_care),
    .nh_o       (ent_nh)
  );

  lpm_tcam_match #(
    .N_ENTRIES(N_ENTRIES), .KEY_W(KEY_W)
  ) u_match (
    .key_i     (key_i),
    .vld_i     (ent_vld),
    .val_i     (ent_val),
    .care_i    (ent_care),
    .hit_vec_o (hit_vec)
  );

  lpm_tcam_prio #(
    .N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)
  ) u_prio (
    .vec_i (hit_vec),
    .any_o (any_hit),
    .idx_o (win_idx)
  );

  always_comb begin
    win_nh = '0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (win_idx == IDX_W'(i)) win_nh = ent_nh[i];
    end
  end

  // table reads use pre-write contents, so a same-cycle write is not seen
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_hit_o   <= 1'b0;
      res_nh_o    <= '0;
    end else begin
      res_valid_o <= key_valid_i;
      if (key_valid_i) begin
        res_hit_o <= any_hit;
        res_nh_o  <= any_hit ? win_nh : '0;
      end
    end
  end
endmodule

// File: rtl/lpm_tcam_chk.sv
module lpm_tcam_chk #(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned NH_W      = 8,
  parameter int unsigned IDX_W     = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [IDX_W-1:0] wr_idx_i,
  input logic             wr_valid_i,
  input logic             key_valid_i,
  input logic             res_valid_o,
  input logic             res_hit_o,
  input logic [NH_W-1:0]  res_nh_o
);
  logic [N_ENTRIES-1:0] shadow_vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_vld <= '0;
    else if (wr_en_i) begin
      for (int i = 0; i < N_ENTRIES; i++)
        if (wr_idx_i == IDX_W'(i)) shadow_vld[i] <= wr_valid_i;
    end
  end

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!res_valid_o && !res_hit_o && res_nh_o == '0));

  p_strobe_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_i |=> res_valid_o);

  p_no_stray_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_i |=> !res_valid_o);

  p_empty_miss_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_valid_i && shadow_vld == '0) |=> !res_hit_o);

  p_miss_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_hit_o |-> res_nh_o == '0);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_valid_i |=> ($stable(res_hit_o) && $stable(res_nh_o)));
endmodule

bind lpm_tcam lpm_tcam_chk #(
  .N_ENTRIES(N_ENTRIES), .NH_W(NH_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .wr_valid_i  (wr_valid_i),
  .key_valid_i (key_valid_i),
  .res_valid_o (res_valid_o),
  .res_hit_o   (res_hit_o),
  .res_nh_o    (res_nh_o)
);

// File: tb/lpm_tcam_tb_top.sv
module lpm_tcam_tb_top;
  localparam int N = 16;
  localparam int KW = 32;
  localparam int NW = 8;

  logic clk_i = 0;
  logic rst_ni = 0;
  logic wr_en_i = 0;
  logic [3:0] wr_idx_i = 0;
  logic wr_valid_i = 0;
  logic [KW-1:0] wr_value_i = 0, wr_care_i = 0;
  logic [NW-1:0] wr_nh_i = 0;
  logic key_valid_i = 0;
  logic [KW-1:0] key_i = 0;
  logic res_valid_o, res_hit_o;
  logic [NW-1:0] res_nh_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic          m_vld  [N];
  logic [KW-1:0] m_val  [N];
  logic [KW-1:0] m_care [N];
  logic [NW-1:0] m_nh   [N];
  logic          last_hit;
  logic [NW-1:0] last_nh;

  always #4 clk_i = ~clk_i;

  lpm_tcam dut_i (.*);

  function automatic logic [KW-1:0] pfx(int len);
    logic [KW:0] m;
    m = {(KW+1){1'b1}} << (KW - len);
    return m[KW-1:0];
  endfunction

  function automatic void ref_lookup(input logic [KW-1:0] k, output logic hit, output logic [NW-1:0] nh);
    hit = 0; nh = 0;
    for (int i = 0; i < N; i++)
      if (!hit && m_vld[i] && (((k ^ m_val[i]) & m_care[i]) == 0)) begin
        hit = 1; nh = m_nh[i];
      end
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: optional write and optional lookup, checked after the capture edge
  task automatic step(input bit we, input int idx, input bit v, input logic [KW-1:0] val,
                      input logic [KW-1:0] care, input logic [NW-1:0] nh,
                      input bit kv, input logic [KW-1:0] k, input string req);
    logic eh; logic [NW-1:0] en;
    wr_en_i = we; wr_idx_i = idx[3:0]; wr_valid_i = v; wr_value_i = val;
    wr_care_i = care; wr_nh_i = nh; key_valid_i = kv; key_i = k;
    if (kv) begin
      ref_lookup(k, eh, en);
      last_hit = eh; last_nh = en;
    end
    if (we) begin
      m_vld[idx] = v; m_val[idx] = val; m_care[idx] = care; m_nh[idx] = nh;
    end
    @(posedge clk_i); @(negedge clk_i);
    chk({req, " R2 strobe"}, res_valid_o, kv);
    chk({req, " hit"}, res_hit_o, last_hit);
    chk({req, " nh"}, res_nh_o, last_nh);
    wr_en_i = 0; key_valid_i = 0;
  endtask

  task automatic wr(int idx, bit v, logic [KW-1:0] val, logic [KW-1:0] care, logic [NW-1:0] nh);
    step(1, idx, v, val, care, nh, 0, 0, "wr");
  endtask

  task automatic lk(logic [KW-1:0] k, string req);
    step(0, 0, 0, 0, 0, 0, 1, k, req);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_val[i] = 0; m_care[i] = 0; m_nh[i] = 0; end
    last_hit = 0; last_nh = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 valid in reset", res_valid_o, 0);
    chk("R1 hit in reset", res_hit_o, 0);
    chk("R1 nh in reset", res_nh_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    lk(32'hFFFF_FFFF, "R1 empty table");
    chk("R6 empty miss", res_hit_o, 0);

    // R8 default route at the last index
    wr(15, 1, 32'hDEAD_BEEF, pfx(0), 8'h0F);
    lk(32'h1234_5678, "R8 default");
    chk("R8 default nh", res_nh_o, 8'h0F);
    // R3 stored value outside care bits ignored
    wr(2, 1, 32'h0A0B_FFFF, pfx(16), 8'h22);
    lk(32'h0A0B_0000, "R3 dont care");
    chk("R3 nh", res_nh_o, 8'h22);
    // R4 longer prefix at lower index wins
    wr(1, 1, 32'h0A0B_0C00, pfx(24), 8'h11);
    lk(32'h0A0B_0C99, "R4 overlap");
    chk("R4 nh", res_nh_o, 8'h11);
    lk(32'h0A0B_0D99, "R4 shorter only");
    // R9 hold
    step(0, 0, 0, 0, 0, 0, 0, 0, "R9 hold");
    chk("R9 nh held", res_nh_o, 8'h22);
    // R7 same-cycle write then later lookup
    step(1, 0, 1, 32'h0A0B_0D00, pfx(32), 8'h33, 1, 32'h0A0B_0D00, "R7 same cycle");
    chk("R7 old contents", res_nh_o, 8'h22);
    lk(32'h0A0B_0D00, "R7 next lookup");
    chk("R7 new contents", res_nh_o, 8'h33);
    // R5 invalidate, keep contents
    wr(0, 0, 32'h0A0B_0D00, pfx(32), 8'h33);
    lk(32'h0A0B_0D00, "R5 invalid");
    chk("R5 nh", res_nh_o, 8'h22);
    // R6 miss after removing default
    wr(15, 0, 0, 0, 8'h0F);
    lk(32'hC000_0001, "R6 miss");
    chk("R6 nh zero", res_nh_o, 0);

    // random phase
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < 4000; c++) begin
      bit we, kv, v;
      int idx, len, src;
      logic [KW-1:0] k;
      we = ($urandom % 4) == 0;
      kv = ($urandom % 4) != 0;
      idx = $urandom % N;
      len = $urandom % 33;
      v = ($urandom % 10) != 0;
      src = $urandom % N;
      k = ($urandom % 3 == 0) ? $urandom : (m_val[src] ^ (($urandom) >> ($urandom % 33)));
      step(we, idx, v, $urandom, pfx(len), NW'($urandom), kv, k, "R3 R4 random");
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk_i); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule